// File: doc/BRIEF.md
# Tagged memory request issuer

This block sits on the client side of a packet-based memory controller and turns queued commands (read, acknowledged write and posted write) into beats on a valid/ready request bus. Each command arrives at the head of a command FIFO with its kind, a command code, a cube ID, a destination address and a payload length in bytes. The issuer pops a command only when it can finish the whole request. Three conditions must hold: the request bus must be idle, a tag must be free if the request needs one, and enough response-buffer space must be free to take the full response the moment it arrives.

Each non-posted request gets the lowest free in-flight tag from a bitmap pool. That tag stays busy until the response logic reports that the last response beat for it has been retired. Response space is tracked as a credit of free buffer beats. It is charged at issue and refunded one beat per retired response beat. Write payloads come from a payload FIFO head and leave as bus-width beats, with start-of-packet and end-of-packet markers. When the length is not a whole number of beats, the final beat keeps the leftover bytes in its low-order lanes and zeroes the rest.

Top module: `tag_req_issuer`

## Requirements
- R1: After reset, `req_valid` and `cmd_pop` are low, `credit_level` equals CRED_BEATS, and every tag is free.
- R2: A beat is accepted only in a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, all request fields hold their values and `req_valid` stays high.
- R3: A non-posted request (kind 2'b00 read, kind 2'b01 write) carries the lowest-numbered tag that is not held by an outstanding request.
- R4: A posted write (kind 2'b10) takes no tag, drives `req_tag` to zero and needs no response credit. It can issue while every tag is busy or while the credit is zero.
- R5: A tag becomes free again only when a retire beat with `rt_last` high names it. Retire beats with `rt_last` low leave it busy.
- R6: While every tag is busy, a pending non-posted command is not popped and no request is driven.
- R7: The response need is ceil(len/bytes-per-beat) beats for a read, 1 for a write and 0 for a posted write. A command issues only if `credit_level` is at least its need, including the case where the two are equal. `credit_level` drops by the need in the cycle after the pop and rises by one for each retire beat.
- R8: A read is a single beat with both `req_sop` and `req_eop` high. A write or posted write of len bytes (1 to MAX_BEATS times bytes-per-beat) takes ceil(len/bytes-per-beat) beats, with `req_sop` on the first beat only and `req_eop` on the last beat only. No idle cycle appears between the beats while `req_ready` stays high.
- R9: On the final beat of a write whose len is not a whole multiple of the beat size, the low (len mod bytes-per-beat) bytes of `req_data` equal `pay_data` and all higher bytes are zero. Every other write beat passes `pay_data` unchanged, and reads drive zero data.
- R10: `pay_pop` is high exactly on accepted write and posted-write beats.
- R11: `req_cmd`, `req_cube` and `req_addr` equal the popped command's fields and stay constant on every beat of its burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command FIFO is not empty |
| cmd_pop | output | 1 | Takes the head command this cycle |
| cmd_kind | input | 2 | 00 read, 01 write, 10 posted write |
| cmd_code | input | CMD_W (6) | Command code |
| cmd_cube | input | CUBE_W (3) | Target cube ID |
| cmd_addr | input | ADDR_W (34) | Destination address |
| cmd_len | input | LEN_W | Payload or read length in bytes |
| pay_data | input | DATA_W | Head of the write payload FIFO |
| pay_pop | output | 1 | Payload beat consumed |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Controller accepts a beat |
| req_sop | output | 1 | First beat of a request |
| req_eop | output | 1 | Last beat of a request |
| req_tag | output | TAG_W (9) | In-flight tag, zero for posted writes |
| req_cmd | output | CMD_W (6) | Command code |
| req_cube | output | CUBE_W (3) | Cube ID |
| req_addr | output | ADDR_W (34) | Destination address |
| req_data | output | DATA_W | Write payload beat |
| rt_valid | input | 1 | One response beat retired |
| rt_tag | input | TAG_W (9) | Tag of the retired beat |
| rt_last | input | 1 | Final response beat of that tag |
| credit_level | output | CRED_W | Free response-buffer beats |
| tag_exhausted | output | 1 | No free tag is left |

## Verification
The assertions check the following on every cycle: that request fields are held under back-pressure, that a burst continues with no bubble, that a command is popped only while the bus is idle, that credit never exceeds its ceiling or goes below the charge, and that only free tags are handed out and only busy tags are released. Some behaviours can only be shown by the bench's scenarios with known expected values. These are which tag number is chosen, the reuse of a released tag, a tag staying busy across non-final retire beats, exact credit values after charge and refund, and the byte-exact zeroing of a partial final beat.

// File: rtl/tri_pkg.sv
package tri_pkg;
  typedef enum logic [1:0] {
    KIND_READ   = 2'b00,
    KIND_WRITE  = 2'b01,
    KIND_POSTED = 2'b10
  } req_kind_e;
endpackage

// File: rtl/tri_tag_pool.sv
module tri_tag_pool #(
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             rel,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             any_free,
  output logic [TAG_W-1:0] free_tag
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [NUM_TAGS-1:0] free_q, free_n;

  // lowest free tag wins
  always_comb begin
    free_tag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (free_q[i]) free_tag = TAG_W'(i);
    end
    any_free = |free_q;
  end

  always_comb begin
    free_n = free_q;
    if (rel)   free_n[rel_tag]  = 1'b1;
    if (alloc) free_n[free_tag] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_n;
  end

  p_alloc_has_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> any_free);
  p_release_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> !free_q[rel_tag]);
  p_alloc_marks_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(rel && rel_tag == free_tag)) |=> !free_q[$past(free_tag)]);
endmodule

// File: rtl/tri_credit.sv
module tri_credit #(
  parameter int CRED_BEATS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic [$clog2(CRED_BEATS+1)-1:0]   need,
  input  logic                              ret,
  output logic [$clog2(CRED_BEATS+1)-1:0]   level,
  output logic                              enough
);
  localparam int CRED_W = $clog2(CRED_BEATS + 1);

  logic [CRED_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (take) cnt_n = cnt_n - need;
    if (ret)  cnt_n = cnt_n + CRED_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CRED_W'(CRED_BEATS);
    else        cnt_q <= cnt_n;
  end

  assign level  = cnt_q;
  assign enough = (cnt_q >= need);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CRED_W'(CRED_BEATS));
  p_take_covered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt_q >= need));
endmodule

// File: rtl/tri_burst_seq.sv
module tri_burst_seq
  import tri_pkg::*;
#(
  parameter int TAG_W     = 9,
  parameter int CMD_W     = 6,
  parameter int CUBE_W    = 3,
  parameter int ADDR_W    = 34,
  parameter int DATA_W    = 256,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  req_kind_e         ld_kind,
  input  logic [CMD_W-1:0]  ld_code,
  input  logic [CUBE_W-1:0] ld_cube,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              req_ready,
  input  logic [DATA_W-1:0] pay_data,
  output logic              busy,
  output logic              req_sop,
  output logic              req_eop,
  output logic [TAG_W-1:0]  req_tag,
  output logic [CMD_W-1:0]  req_cmd,
  output logic [CUBE_W-1:0] req_cube,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              pay_pop
);
  localparam int BYTES   = DATA_W / 8;
  localparam int BYTE_SH = $clog2(BYTES);
  localparam int BEAT_W  = $clog2(MAX_BEATS + 1);

  logic              busy_q, busy_n;
  logic [BEAT_W-1:0] beat_q, beat_n, nbeat_q, nbeat_n;
  logic [BYTE_SH-1:0] rem_q, rem_n;
  logic              wr_q, wr_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [CMD_W-1:0]  code_q, code_n;
  logic [CUBE_W-1:0] cube_q, cube_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W:0]    len_sum;
  logic              last_beat, xfer;

  assign len_sum   = {1'b0, ld_len} + (LEN_W+1)'(BYTES - 1);
  assign last_beat = (beat_q == nbeat_q - BEAT_W'(1));
  assign xfer      = busy_q && req_ready;

  always_comb begin
    busy_n  = busy_q;
    beat_n  = beat_q;
    nbeat_n = nbeat_q;
    rem_n   = rem_q;
    wr_n    = wr_q;
    tag_n   = tag_q;
    code_n  = code_q;
    cube_n  = cube_q;
    addr_n  = addr_q;
    if (load) begin
      busy_n  = 1'b1;
      beat_n  = '0;
      wr_n    = (ld_kind != KIND_READ);
      nbeat_n = (ld_kind == KIND_READ) ? BEAT_W'(1) : BEAT_W'(len_sum >> BYTE_SH);
      rem_n   = (ld_kind == KIND_READ) ? '0 : ld_len[BYTE_SH-1:0];
      tag_n   = (ld_kind == KIND_POSTED) ? '0 : ld_tag;
      code_n  = ld_code;
      cube_n  = ld_cube;
      addr_n  = ld_addr;
    end else if (xfer) begin
      if (last_beat) busy_n = 1'b0;
      else           beat_n = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      nbeat_q <= BEAT_W'(1);
      rem_q   <= '0;
      wr_q    <= 1'b0;
      tag_q   <= '0;
      code_q  <= '0;
      cube_q  <= '0;
      addr_q  <= '0;
    end else begin
      busy_q  <= busy_n;
      beat_q  <= beat_n;
      nbeat_q <= nbeat_n;
      rem_q   <= rem_n;
      wr_q    <= wr_n;
      tag_q   <= tag_n;
      code_q  <= code_n;
      cube_q  <= cube_n;
      addr_q  <= addr_n;
    end
  end

  // partial final beat: keep low rem bytes, zero the rest
  always_comb begin
    req_data = '0;
    if (busy_q && wr_q) begin
      for (int b = 0; b < BYTES; b++) begin
        if (!last_beat || rem_q == '0 || BYTE_SH'(b) < rem_q)
          req_data[b*8 +: 8] = pay_data[b*8 +: 8];
      end
    end
  end

  assign busy     = busy_q;
  assign req_sop  = busy_q && (beat_q == '0);
  assign req_eop  = busy_q && last_beat;
  assign req_tag  = tag_q;
  assign req_cmd  = code_q;
  assign req_cube = cube_q;
  assign req_addr = addr_q;
  assign pay_pop  = xfer && wr_q;

  p_hold_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_ready) |=> busy_q);
  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_ready) |=> $stable(req_addr));
  p_hold_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_ready) |=> $stable(req_tag));
  p_no_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !req_eop) |=> (busy_q && !req_sop));
  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
  p_burst_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !req_eop) |=> ($stable(req_cmd) && $stable(req_cube)));
endmodule

// File: rtl/tag_req_issuer.sv
module tag_req_issuer
  import tri_pkg::*;
#(
  parameter int TAG_W      = 9,
  parameter int CMD_W      = 6,
  parameter int CUBE_W     = 3,
  parameter int ADDR_W     = 34,
  parameter int DATA_W     = 256,
  parameter int MAX_BEATS  = 4,
  parameter int CRED_BEATS = 16,
  localparam int LEN_W     = $clog2(MAX_BEATS * (DATA_W / 8) + 1),
  localparam int CRED_W    = $clog2(CRED_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_pop,
  input  logic [1:0]        cmd_kind,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [CUBE_W-1:0] cmd_cube,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] pay_data,
  output logic              pay_pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sop,
  output logic              req_eop,
  output logic [TAG_W-1:0]  req_tag,
  output logic [CMD_W-1:0]  req_cmd,
  output logic [CUBE_W-1:0] req_cube,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rt_valid,
  input  logic [TAG_W-1:0]  rt_tag,
  input  logic              rt_last,
  output logic [CRED_W-1:0] credit_level,
  output logic              tag_exhausted
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  req_kind_e         kind;
  logic              needs_tag, any_free, enough, seq_busy;
  logic [TAG_W-1:0]  free_tag;
  logic [CRED_W-1:0] need;
  logic [LEN_W:0]    len_sum;

  assign kind      = req_kind_e'(cmd_kind);
  assign needs_tag = (kind != KIND_POSTED);
  assign len_sum   = {1'b0, cmd_len} + (LEN_W+1)'((DATA_W / 8) - 1);

  always_comb begin
    case (kind)
      KIND_READ:  need = CRED_W'(len_sum >> BYTE_SH);
      KIND_WRITE: need = CRED_W'(1);
      default:    need = '0;
    endcase
  end

  assign cmd_pop = cmd_valid && !seq_busy && enough && (!needs_tag || any_free);

  tri_tag_pool #(.TAG_W(TAG_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (cmd_pop && needs_tag),
    .rel      (rt_valid && rt_last),
    .rel_tag  (rt_tag),
    .any_free (any_free),
    .free_tag (free_tag)
  );

  tri_credit #(.CRED_BEATS(CRED_BEATS)) u_cred (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (cmd_pop),
    .need   (need),
    .ret    (rt_valid),
    .level  (credit_level),
    .enough (enough)
  );

  tri_burst_seq #(
    .TAG_W(TAG_W), .CMD_W(CMD_W), .CUBE_W(CUBE_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_pop),
    .ld_kind   (kind),
    .ld_code   (cmd_code),
    .ld_cube   (cmd_cube),
    .ld_addr   (cmd_addr),
    .ld_len    (cmd_len),
    .ld_tag    (free_tag),
    .req_ready (req_ready),
    .pay_data  (pay_data),
    .busy      (seq_busy),
    .req_sop   (req_sop),
    .req_eop   (req_eop),
    .req_tag   (req_tag),
    .req_cmd   (req_cmd),
    .req_cube  (req_cube),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .pay_pop   (pay_pop)
  );

  assign req_valid     = seq_busy;
  assign tag_exhausted = !any_free;

  p_stall_no_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_exhausted && kind != KIND_POSTED) |-> !cmd_pop);
  p_posted_zero_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && kind == KIND_POSTED) |=> (req_tag == '0));
endmodule

// File: tb/tag_req_issuer_bench.sv
`timescale 1ns/1ps
module tag_req_issuer_bench;
  localparam int TAG_W = 3, CMD_W = 6, CUBE_W = 3, ADDR_W = 34;
  localparam int DATA_W = 64, MAX_BEATS = 4, CRED_BEATS = 16;
  localparam int BYTES = DATA_W / 8;
  localparam int LEN_W = $clog2(MAX_BEATS * BYTES + 1);
  localparam int CRED_W = $clog2(CRED_BEATS + 1);

  typedef struct packed {
    logic [1:0] kind;
    logic [5:0] len;
    logic [2:0] cube;
    logic [2:0] tag;
    logic [5:0] cred;
  } vec_t;

  // kind 0 read, 1 write, 2 posted; expected tag and credit after issue
  localparam vec_t VECS [8] = '{
    '{2'd0, 6'd8,  3'd1, 3'd0, 6'd15},
    '{2'd0, 6'd20, 3'd2, 3'd1, 6'd12},
    '{2'd1, 6'd32, 3'd3, 3'd2, 6'd11},
    '{2'd2, 6'd13, 3'd4, 3'd0, 6'd11},
    '{2'd1, 6'd3,  3'd5, 3'd3, 6'd10},
    '{2'd0, 6'd32, 3'd6, 3'd4, 6'd6},
    '{2'd2, 6'd24, 3'd7, 3'd0, 6'd6},
    '{2'd1, 6'd9,  3'd0, 3'd5, 6'd5}
  };

  logic clk, rst_n;
  logic cmd_valid, cmd_pop;
  logic [1:0] cmd_kind;
  logic [CMD_W-1:0] cmd_code;
  logic [CUBE_W-1:0] cmd_cube;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0] cmd_len;
  logic [DATA_W-1:0] pay_data, req_data;
  logic pay_pop, req_valid, req_ready, req_sop, req_eop;
  logic [TAG_W-1:0] req_tag, rt_tag;
  logic [CMD_W-1:0] req_cmd;
  logic [CUBE_W-1:0] req_cube;
  logic [ADDR_W-1:0] req_addr;
  logic rt_valid, rt_last, tag_exhausted;
  logic [CRED_W-1:0] credit_level;

  int n_chk, n_bad;

  tag_req_issuer #(
    .TAG_W(TAG_W), .CMD_W(CMD_W), .CUBE_W(CUBE_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .CRED_BEATS(CRED_BEATS)
  ) u_tag_req_issuer (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return {BYTES{8'(8'h11 * (i + 1))}};
  endfunction

  function automatic logic [DATA_W-1:0] exp_beat(input int i, input int n, input int len);
    logic [DATA_W-1:0] d;
    int r;
    d = pat(i);
    r = len % BYTES;
    if (i == n - 1 && r != 0)
      for (int b = 0; b < BYTES; b++) if (b >= r) d[b*8 +: 8] = 8'h00;
    return d;
  endfunction

  task automatic set_cmd(input int kind, input int len, input int cube, input int idx);
    cmd_kind  = 2'(kind);
    cmd_len   = LEN_W'(len);
    cmd_cube  = CUBE_W'(cube);
    cmd_addr  = 34'h2_0000_0000 + ADDR_W'(idx * 64);
    cmd_code  = CMD_W'(8 + idx);
    cmd_valid = 1'b1;
  endtask

  task automatic issue(input int kind, input int len, input int cube, input int idx,
                       input int etag, input int ecred);
    int n, w;
    set_cmd(kind, len, cube, idx);
    #1;
    w = 0;
    while (!cmd_pop && w < 50) begin @(negedge clk); #1; w++; end
    chk(cmd_pop, "R7 command popped", 64'(cmd_pop), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(credit_level == CRED_W'(ecred), "R7 credit after issue", 64'(credit_level), 64'(ecred));
    n = (kind == 0) ? 1 : (len + BYTES - 1) / BYTES;
    for (int i = 0; i < n; i++) begin
      pay_data = pat(i);
      #1;
      chk(req_valid, "R8 valid on beat", 64'(req_valid), 1);
      chk(req_sop == (i == 0), "R8 sop", 64'(req_sop), 64'(i == 0));
      chk(req_eop == (i == n - 1), "R8 eop", 64'(req_eop), 64'(i == n - 1));
      chk(req_data == ((kind == 0) ? '0 : exp_beat(i, n, len)), "R9 beat data",
          64'(req_data), (kind == 0) ? 64'd0 : 64'(exp_beat(i, n, len)));
      chk(pay_pop == (kind != 0), "R10 payload pop", 64'(pay_pop), 64'(kind != 0));
      chk(req_tag == TAG_W'(etag), (kind == 2) ? "R4 posted tag" : "R3 lowest tag",
          64'(req_tag), 64'(etag));
      chk(req_addr == 34'h2_0000_0000 + ADDR_W'(idx * 64) && req_cube == CUBE_W'(cube)
          && req_cmd == CMD_W'(8 + idx), "R11 fields", 64'(req_addr), 64'(idx));
      @(negedge clk);
    end
    #1;
    chk(!req_valid, "R8 burst ended", 64'(req_valid), 0);
  endtask

  task automatic retire(input int tag, input bit last);
    rt_valid = 1'b1; rt_tag = TAG_W'(tag); rt_last = last;
    @(negedge clk);
    rt_valid = 1'b0; rt_last = 1'b0;
  endtask

  task automatic expect_stall(input string req, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      #1;
      chk(!cmd_pop && !req_valid, req, 64'(cmd_pop), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = '0; cmd_code = '0; cmd_cube = '0;
    cmd_addr = '0; cmd_len = '0; pay_data = '0; req_ready = 1'b1;
    rt_valid = 1'b0; rt_tag = '0; rt_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!req_valid && !cmd_pop, "R1 idle after reset", 64'(req_valid), 0);
    chk(credit_level == CRED_W'(CRED_BEATS), "R1 full credit", 64'(credit_level), CRED_BEATS);
    chk(!tag_exhausted, "R1 tags free", 64'(tag_exhausted), 0);
    @(negedge clk);

    foreach (VECS[v])
      issue(VECS[v].kind, VECS[v].len, VECS[v].cube, v, VECS[v].tag, VECS[v].cred);

    // R5: tag 1 frees only on its last retire beat
    retire(1, 1'b0); retire(1, 1'b0); retire(1, 1'b1);
    #1; chk(credit_level == 8, "R7 refund per beat", 64'(credit_level), 8);
    issue(0, 8, 1, 8, 1, 7);
    retire(4, 1'b0); retire(4, 1'b0);
    issue(0, 8, 2, 9, 6, 8);   // R5 tag 4 still busy
    issue(0, 8, 3, 10, 7, 7);
    #1; chk(tag_exhausted, "R6 pool empty", 64'(tag_exhausted), 1);
    set_cmd(0, 8, 4, 11);
    expect_stall("R6 no tag stall", 5);
    issue(2, 8, 4, 12, 0, 7);  // R4 posted goes while tags are busy

    // R7 credit boundary
    retire(0, 1'b1);
    issue(0, 32, 5, 13, 0, 4);
    retire(2, 1'b1);
    issue(0, 32, 6, 14, 2, 1);
    retire(3, 1'b1);
    set_cmd(0, 24, 7, 15);
    expect_stall("R7 credit short stall", 5);
    retire(5, 1'b0);
    issue(0, 24, 7, 15, 3, 0); // need equals credit

    // R2 back-pressure during a posted burst with zero credit (R4)
    set_cmd(2, 16, 1, 16);
    req_ready = 1'b0;
    #1; while (!cmd_pop) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
    pay_data = pat(0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_valid && req_sop && !pay_pop && req_addr == 34'h2_0000_0000 + 34'(16 * 64),
          "R2 hold under back-pressure", 64'(req_valid), 1);
      @(negedge clk);
    end
    req_ready = 1'b1;
    #1; chk(pay_pop && req_sop, "R2 beat on ready", 64'(pay_pop), 1);
    @(negedge clk); pay_data = pat(1); #1;
    chk(req_eop && req_data == pat(1) && req_tag == '0, "R4 posted last beat",
        64'(req_data), 64'(pat(1)));
    @(negedge clk); #1;
    chk(!req_valid && credit_level == 0, "R7 posted no charge", 64'(credit_level), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule